// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor that keeps one working value in an accumulator. Instructions and data sit in a single memory reached through one synchronous port. Every instruction passes through a fixed register-transfer sequence. The program counter is copied into the memory address register. A read is issued, and the returned word is latched into the memory data register. The word then moves into the current instruction register, where it is decoded and executed. Operand reads and stores reuse the same address and data registers and the same bus.

Ten operations are provided: load, store, add, subtract, an unconditional jump, jump-if-zero, jump-if-non-negative, read from an input port, write to an output port, and stop. Input values arrive on a ready/valid port. Output values leave as a one-cycle valid strobe with data. The reset is asynchronous and active low, and its release passes through a two-flop synchronizer inside the core.

Top module: `acc_core`

## Requirements
- R1: While reset is held, `mem_rd`, `mem_we`, `out_valid`, `in_ready` and `halted` are all 0. The first memory read after reset is at address 0.
- R2: Instruction fetches read addresses in sequence: the program counter advances by exactly 1 per fetch unless a taken jump replaces it. The read data is used one cycle after the request.
- R3: The input instruction raises `in_ready` and waits for as long as `in_valid` stays low. When both are high at a clock edge, `in_data` becomes the accumulator value.
- R4: The output instruction gives a `out_valid` pulse that lasts exactly one cycle, with `out_data` equal to the accumulator.
- R5: Load (opcode 1) reads the word at the operand address into the accumulator.
- R6: Store (opcode 2) performs one write of the accumulator to the operand address. `mem_we` and `mem_rd` are never high in the same cycle.
- R7: Add (opcode 3) and subtract (opcode 4) combine the accumulator with the memory operand modulo 2^12 and put the result in the accumulator.
- R8: Jump (opcode 5) always continues execution at the operand address.
- R9: Jump-if-zero (opcode 6) is taken only when the accumulator is 0. Otherwise the next sequential instruction runs.
- R10: Jump-if-non-negative (opcode 7) is taken when accumulator bit 11 is 0, which includes zero. Otherwise execution falls through.
- R11: Stop (opcode 0) and the unused opcodes 10 to 15 set `halted`. Once halted, the core stays halted until reset and issues no memory, input or output activity.
- R12: An instruction word has the opcode in bits 11:8 and the operand address in bits 7:0. Input is opcode 8 and output is opcode 9. Data words are 12-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address, taken from the address register |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data, taken from the data register |
| mem_rdata | input | 12 | Read data, one cycle after `mem_rd` |
| in_data | input | 12 | Value supplied to the input instruction |
| in_valid | input | 1 | Input value is available |
| in_ready | output | 1 | Core is waiting for an input value |
| out_data | output | 12 | Value written by the output instruction |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| halted | output | 1 | Core has stopped |

## Verification
Some properties are checked by assertions on every cycle:
- read and write never overlap;
- a store writes the accumulator;
- the output strobe is a single cycle and carries the accumulator;
- an input handshake lands in the accumulator;
- a fetch reads at the program counter;
- the halted state is sticky and quiet.

Other behaviour can only be shown by the bench's scenarios:
- arithmetic wraparound;
- the exact sequence of fetch and operand addresses;
- stalling for a late input;
- which path each conditional jump takes for zero, positive and negative accumulators.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HLT = 4'd0,
    OP_LDA = 4'd1,
    OP_STA = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_BRA = 4'd5,
    OP_BRZ = 4'd6,
    OP_BRP = 4'd7,
    OP_INP = 4'd8,
    OP_OUT = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FWAIT,
    ST_FCIR,
    ST_DECODE,
    ST_OREAD,
    ST_OWAIT,
    ST_EXEC,
    ST_STORE,
    ST_INWAIT,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic pc_inc;
    logic pc_load;
    logic mdr_mem;
    logic mdr_acc;
    logic cir_load;
    logic acc_alu;
    logic acc_in;
    logic mem_rd;
    logic mem_we;
    logic out_fire;
    logic in_ready;
    logic halted;
  } ctrl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 12
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result
);

  always_comb begin
    case (op)
      OP_ADD:  result = acc + operand;
      OP_SUB:  result = acc - operand;
      default: result = operand;
    endcase
  end

endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_pkg::*;
#(
  parameter int DW = 12
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  output logic          take
);

  logic acc_zero;
  logic acc_nonneg;

  assign acc_zero   = (acc == '0);
  assign acc_nonneg = ~acc[DW-1];

  always_comb begin
    case (op)
      OP_BRA:  take = 1'b1;
      OP_BRZ:  take = acc_zero;
      OP_BRP:  take = acc_nonneg;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sn,
  input  op_e    op,
  input  logic   take,
  input  logic   in_valid,
  output ctrl_t  ctl,
  output state_e state_q
);

  state_e state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    case (state_q)
      ST_FADDR: begin
        ctl.mar_pc = 1'b1;
        state_d    = ST_FREAD;
      end
      ST_FREAD: begin
        ctl.mem_rd = 1'b1;
        ctl.pc_inc = 1'b1;
        state_d    = ST_FWAIT;
      end
      ST_FWAIT: begin
        ctl.mdr_mem = 1'b1;
        state_d     = ST_FCIR;
      end
      ST_FCIR: begin
        ctl.cir_load = 1'b1;
        state_d      = ST_DECODE;
      end
      ST_DECODE: begin
        case (op)
          OP_LDA, OP_ADD, OP_SUB: begin
            ctl.mar_ir = 1'b1;
            state_d    = ST_OREAD;
          end
          OP_STA: begin
            ctl.mar_ir  = 1'b1;
            ctl.mdr_acc = 1'b1;
            state_d     = ST_STORE;
          end
          OP_BRA, OP_BRZ, OP_BRP: begin
            ctl.pc_load = take;
            state_d     = ST_FADDR;
          end
          OP_INP: state_d = ST_INWAIT;
          OP_OUT: begin
            ctl.out_fire = 1'b1;
            state_d      = ST_FADDR;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_OREAD: begin
        ctl.mem_rd = 1'b1;
        state_d    = ST_OWAIT;
      end
      ST_OWAIT: begin
        ctl.mdr_mem = 1'b1;
        state_d     = ST_EXEC;
      end
      ST_EXEC: begin
        ctl.acc_alu = 1'b1;
        state_d     = ST_FADDR;
      end
      ST_STORE: begin
        ctl.mem_we = 1'b1;
        state_d    = ST_FADDR;
      end
      ST_INWAIT: begin
        ctl.in_ready = 1'b1;
        if (in_valid) begin
          ctl.acc_in = 1'b1;
          state_d    = ST_FADDR;
        end
      end
      ST_HALT: ctl.halted = 1'b1;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_FADDR;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);

  localparam int OPW = DW - AW;

  logic          rst_sn;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic [DW-1:0] cir_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] out_q;
  logic          outv_q;
  logic [AW-1:0] ir_addr;
  op_e           ir_op;
  logic [DW-1:0] alu_y;
  logic          br_take;
  ctrl_t         ctl;
  state_e        state_q;

  assign ir_addr = cir_q[AW-1:0];
  assign ir_op   = op_e'(cir_q[DW-1 -: OPW]);

  acc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .op       (ir_op),
    .take     (br_take),
    .in_valid (in_valid),
    .ctl      (ctl),
    .state_q  (state_q)
  );

  acc_alu #(.DW(DW)) u_alu (
    .op      (ir_op),
    .acc     (acc_q),
    .operand (mdr_q),
    .result  (alu_y)
  );

  acc_branch #(.DW(DW)) u_br (
    .op   (ir_op),
    .acc  (acc_q),
    .take (br_take)
  );

  // program counter
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          pc_q <= '0;
    else if (ctl.pc_load) pc_q <= ir_addr;
    else if (ctl.pc_inc)  pc_q <= pc_q + AW'(1);
  end

  // memory address register
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         mar_q <= '0;
    else if (ctl.mar_pc) mar_q <= pc_q;
    else if (ctl.mar_ir) mar_q <= ir_addr;
  end

  // memory data register
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          mdr_q <= '0;
    else if (ctl.mdr_mem) mdr_q <= mem_rdata;
    else if (ctl.mdr_acc) mdr_q <= acc_q;
  end

  // current instruction register
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)           cir_q <= '0;
    else if (ctl.cir_load) cir_q <= mdr_q;
  end

  // accumulator
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          acc_q <= '0;
    else if (ctl.acc_alu) acc_q <= alu_y;
    else if (ctl.acc_in)  acc_q <= in_data;
  end

  // output port
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_q  <= '0;
      outv_q <= 1'b0;
    end else begin
      outv_q <= ctl.out_fire;
      if (ctl.out_fire) out_q <= acc_q;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_we    = ctl.mem_we;
  assign in_ready  = ctl.in_ready;
  assign out_data  = out_q;
  assign out_valid = outv_q;
  assign halted    = ctl.halted;

  a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_FREAD) |-> (mem_addr == pc_q));

  a_r3_input_lands: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_ready && in_valid) |=> (acc_q == $past(in_data)));

  a_r4_out_single: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |=> !out_valid);

  a_r4_out_is_acc: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> (out_data == acc_q));

  a_r6_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_rd && mem_we));

  a_r6_store_acc: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |-> (mem_wdata == acc_q));

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    halted |=> halted);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    halted |-> (!mem_rd && !mem_we && !in_ready && !out_valid));

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

  localparam int AW = 8;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] in_data;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          halted;

  logic [DW-1:0] mem [2**AW];

  int total = 0;
  int fails = 0;

  logic [DW-1:0] ins_q [8];
  int            nin;
  logic [DW-1:0] outs [16];
  int            nout;
  logic [AW-1:0] rds [32];
  int            nrd;
  int            nwe;
  int            max_run;
  int            rd_after_halt;
  int            unstick;
  int            hung;

  always #2 clk = ~clk;

  acc_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .halted    (halted)
  );

  // memory model: one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] ins(input int op, input int addr);
    return {op[3:0], addr[7:0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input int delay);
    int cyc = 0;
    int rdy_run = 0;
    int halt_at = -1;
    int idx = 0;
    nout = 0; nrd = 0; nwe = 0; max_run = 0;
    rd_after_halt = 0; unstick = 0; hung = 0;
    release_reset();
    while (1) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        if (nout < 16) outs[nout] = out_data;
        nout++;
      end
      if (mem_rd) begin
        if (nrd < 32) rds[nrd] = mem_addr;
        nrd++;
        if (halt_at >= 0) rd_after_halt++;
      end
      if (mem_we) nwe++;
      if (halt_at >= 0 && !halted) unstick++;
      if (in_ready) rdy_run++; else rdy_run = 0;
      if (rdy_run > max_run) max_run = rdy_run;
      if (in_ready && rdy_run > delay && idx < nin) begin
        in_valid = 1'b1;
        in_data  = ins_q[idx];
        idx++;
      end else begin
        in_valid = 1'b0;
      end
      if (halted && halt_at < 0) halt_at = cyc;
      if (halt_at >= 0 && cyc - halt_at >= 20) break;
      if (cyc > 3000) begin
        hung = 1;
        break;
      end
    end
    in_valid = 1'b0;
    chk("R11", "halt reached", hung, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "mem_rd in reset", int'(mem_rd), 0);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 0);
    chk("R1", "halted in reset", int'(halted), 0);
  endtask

  // R3 R4 R2 R1: input and output with a late input
  task automatic t_io(input int delay);
    do_reset();
    mem[0] = ins(8, 0); mem[1] = ins(9, 0);
    mem[2] = ins(8, 0); mem[3] = ins(9, 0); mem[4] = ins(0, 0);
    nin = 2; ins_q[0] = 12'h005; ins_q[1] = 12'hFFD;
    run_prog(delay);
    chk("R4", "output count", nout, 2);
    chk("R3", "first input echoed", int'(outs[0]), 12'h005);
    chk("R3", "second input echoed", int'(outs[1]), 12'hFFD);
    chk("R3", "in_ready wait length", max_run, delay + 1);
    chk("R1", "first read address", int'(rds[0]), 0);
    chk("R2", "read count", nrd, 5);
    for (int i = 0; i < 5; i++) chk("R2", "sequential fetch", int'(rds[i]), i);
    chk("R11", "halted sticky", unstick, 0);
  endtask

  // R5 R6 R7: load, add with wrap, store, subtract, reload
  task automatic t_mem();
    logic [AW-1:0] exp_rd [12];
    do_reset();
    mem[0] = ins(1, 20); mem[1] = ins(3, 21); mem[2] = ins(2, 22);
    mem[3] = ins(4, 23); mem[4] = ins(9, 0);  mem[5] = ins(1, 22);
    mem[6] = ins(9, 0);  mem[7] = ins(0, 0);
    mem[20] = 12'h7FF; mem[21] = 12'h001; mem[23] = 12'h001;
    nin = 0;
    exp_rd = '{8'd0, 8'd20, 8'd1, 8'd21, 8'd2, 8'd3, 8'd23, 8'd4, 8'd5, 8'd22, 8'd6, 8'd7};
    run_prog(0);
    chk("R6", "stored word", int'(mem[22]), 12'h800);
    chk("R6", "write count", nwe, 1);
    chk("R7", "sub result", int'(outs[0]), 12'h7FF);
    chk("R5", "load of stored word", int'(outs[1]), 12'h800);
    chk("R4", "output count", nout, 2);
    chk("R2", "read count", nrd, 12);
    for (int i = 0; i < 12; i++) chk("R5", "read trace", int'(rds[i]), int'(exp_rd[i]));
  endtask

  task automatic load_branch_prog(input bit zero_first);
    if (zero_first) begin
      mem[0] = ins(8, 0); mem[1] = ins(6, 10); mem[2] = ins(7, 20);
      mem[3] = ins(9, 0); mem[4] = ins(0, 0);
    end else begin
      mem[0] = ins(8, 0); mem[1] = ins(7, 20); mem[2] = ins(9, 0);
      mem[3] = ins(0, 0);
    end
    mem[10] = ins(1, 50); mem[11] = ins(9, 0); mem[12] = ins(0, 0);
    mem[20] = ins(1, 51); mem[21] = ins(9, 0); mem[22] = ins(5, 30);
    mem[23] = ins(9, 0);  mem[24] = ins(0, 0);
    mem[30] = ins(1, 52); mem[31] = ins(9, 0); mem[32] = ins(0, 0);
    mem[50] = 12'h0A1; mem[51] = 12'h0B2; mem[52] = 12'h0C3;
  endtask

  task automatic t_branch(input bit zero_first, input logic [DW-1:0] val,
                          input string req, input int n_exp,
                          input int e0, input int e1);
    do_reset();
    load_branch_prog(zero_first);
    nin = 1; ins_q[0] = val;
    run_prog(0);
    chk(req, "output count", nout, n_exp);
    chk(req, "first output", int'(outs[0]), e0);
    if (n_exp > 1) chk("R8", "jump target output", int'(outs[1]), e1);
  endtask

  // R11: undefined opcode stops the core
  task automatic t_undef();
    do_reset();
    mem[0] = ins(15, 0); mem[1] = ins(9, 0); mem[2] = ins(0, 0);
    nin = 0;
    run_prog(0);
    chk("R11", "no output after undefined", nout, 0);
    chk("R11", "reads before halt", nrd, 1);
    chk("R11", "reads after halt", rd_after_halt, 0);
    chk("R11", "writes", nwe, 0);
    chk("R11", "halted sticky", unstick, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_io(0);
    t_io(3);
    t_mem();
    t_branch(1'b1, 12'h000, "R9",  1, 12'h0A1, 0);
    t_branch(1'b1, 12'h005, "R10", 2, 12'h0B2, 12'h0C3);
    t_branch(1'b1, 12'h800, "R9",  1, 12'h800, 0);
    t_branch(1'b0, 12'h000, "R10", 2, 12'h0B2, 12'h0C3);
    t_branch(1'b0, 12'hFFF, "R10", 1, 12'hFFF, 0);
    t_branch(1'b0, 12'h7FF, "R12", 2, 12'h0B2, 12'h0C3);
    t_undef();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule